// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the device-side engine behind a byte-wide status register and a data port. A host that owns the block's locality uses them to move a command in, start it, and drain the response. Command bytes arrive one at a time through the data port. The engine decodes the big-endian 32-bit total length carried in bytes 2 to 5 of the 10-byte header. It keeps the expect flag raised until exactly that many bytes have been stored. After go is written, the stub executor spends two cycles and then offers the stored command back as the response through the same port. Completion is signalled by valid together with data-available, and a 16-bit burst count tells the host how many bytes it may move next.

The engine has five states. Reset places it in IDLE. Writing command-ready enters READY from any state, which also aborts any transfer in flight. The first data byte moves READY to RECEPTION. A header whose length is below 10 or above the 64-byte buffer returns RECEPTION to READY. Go, accepted only when every declared byte has arrived, moves RECEPTION to EXECUTION. When the stub delay expires, EXECUTION moves to COMPLETION, where the host reads the response. Accesses from any locality other than the owning one are screened out at the port.

Top module: `xfer_status_engine`

## Requirements
- R1: After reset the engine is in IDLE. The status byte at offset 0x18 reads 0x80 (valid only) and the burst count reads 0.
- R2: A write to offset 0x18 with bit 6 (command-ready, 0x40) set enters READY from any state and discards any stored command or response. The status then reads 0xC0 and the burst count reads 64.
- R3: Bytes written to offset 0x24 in READY or RECEPTION are stored in order. Status bit 3 (expect, 0x08) stays set while the length is still unknown or fewer bytes than the declared length are stored, and it clears in the cycle after the final byte is written.
- R4: Data bytes written after the declared length has been reached, or when the buffer is full, are dropped, and the burst count does not change.
- R5: A declared length (big-endian, header bytes 2..5) below 10 or above 64 returns the engine to READY with an empty buffer as soon as header byte 5 is written.
- R6: The burst count is 16 bits wide, with its low byte at 0x19 and its high byte at 0x1A. It shows the free buffer space in READY and RECEPTION, the unread response bytes in COMPLETION, and 0 in IDLE and EXECUTION.
- R7: A write of status bit 5 (go, 0x20) has no effect unless the engine is in RECEPTION with expect clear.
- R8: An accepted go enters EXECUTION, where the status reads 0x00. Exactly two cycles later the engine enters COMPLETION, and the status reads 0x90 (valid and data-available, bit 4).
- R9: In COMPLETION, each read of 0x24 returns the next byte of the looped-back command, in the order written. Once the last byte has been read, data-available is 0.
- R10: An access whose locality differs from the owning locality has no effect, and a read from such a locality returns 0xFF.
- R11: A read of 0x24 outside COMPLETION, or after the response is drained, returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| owner_loc | input | LOC_W | Locality that currently owns the block |
| acc_loc | input | LOC_W | Locality of the present access |
| reg_addr | input | ADDR_W | Byte offset of the access within the locality window |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; reading the data port consumes a byte |
| reg_rdata | output | 8 | Read data, combinational from the current state |

## Verification
Read data is produced combinationally from registered state. A write therefore becomes visible on the first read that is sampled after the clock edge that accepted it, and the bench reads half a cycle after every edge. The stub delay is checked by reading the status on each of the three cycles that follow the go edge and expecting 0x00, 0x00 and then 0x90. Each burst-count check is placed immediately after the write or read it depends on, so each counter step is compared at the cycle it takes effect. The response bytes are queued when they are written and compared when they are popped.

// File: rtl/xse_pkg.sv
package xse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RX    = 3'd2,
        ST_EXEC  = 3'd3,
        ST_COMPL = 3'd4
    } xse_state_e;

    // register offsets inside one locality window
    localparam int OFS_STS    = 'h18;
    localparam int OFS_BURST0 = 'h19;
    localparam int OFS_BURST1 = 'h1A;
    localparam int OFS_FIFO   = 'h24;

    // status byte bit positions
    localparam int BIT_VALID  = 7;
    localparam int BIT_CRDY   = 6;
    localparam int BIT_GO     = 5;
    localparam int BIT_AVAIL  = 4;
    localparam int BIT_EXPECT = 3;

    // header layout
    localparam int HDR_BYTES = 10;
    localparam int LEN_FIRST = 2;
    localparam int LEN_LAST  = 5;

endpackage

// File: rtl/xse_len_capture.sv
module xse_len_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shift_en,
    input  logic [7:0]  byte_in,
    output logic [31:0] len_q,
    output logic [31:0] len_nx
);

    // big-endian: earliest byte lands in the most significant position
    assign len_nx = {len_q[23:0], byte_in};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len_q <= '0;
        end else if (shift_en) begin
            len_q <= len_nx;
        end
    end

endmodule

// File: rtl/xse_buffer.sv
module xse_buffer #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/xse_readmux.sv
module xse_readmux #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              loc_ok,
    input  logic [7:0]        sts_byte,
    input  logic [15:0]       burst,
    input  logic              fifo_ok,
    input  logic [7:0]        fifo_byte,
    output logic [7:0]        rdata
);

    import xse_pkg::*;

    always_comb begin
        rdata = 8'h00;
        if (!loc_ok) begin
            rdata = 8'hFF;
        end else if (addr == ADDR_W'(OFS_STS)) begin
            rdata = sts_byte;
        end else if (addr == ADDR_W'(OFS_BURST0)) begin
            rdata = burst[7:0];
        end else if (addr == ADDR_W'(OFS_BURST1)) begin
            rdata = burst[15:8];
        end else if (addr == ADDR_W'(OFS_FIFO)) begin
            rdata = fifo_ok ? fifo_byte : 8'h00;
        end
    end

endmodule

// File: rtl/xfer_status_engine.sv
module xfer_status_engine #(
    parameter int LOC_W    = 3,
    parameter int ADDR_W   = 12,
    parameter int DEPTH    = 64,
    parameter int EXEC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  owner_loc,
    input  logic [LOC_W-1:0]  acc_loc,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata
);

    import xse_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam int EL_W  = $clog2(EXEC_LAT + 1);

    xse_state_e       state_q, state_d;
    logic [CNT_W-1:0] wr_cnt_q, rd_cnt_q, unread_w;
    logic [EL_W-1:0]  exec_cnt_q;
    logic             len_known_q;
    logic [31:0]      len_q, len_nx;
    logic [7:0]       buf_rdata;

    logic loc_ok, sts_hit, fifo_hit;
    logic cmd_rdy_req, go_req, wr_fifo, rd_fifo;
    logic need_more, byte_take, hit_len_last, len_bad, shift_en;
    logic exec_done, pop, clr_all;
    logic sts_valid, sts_crdy, sts_expect, sts_avail;
    logic [7:0]  sts_byte;
    logic [15:0] burst_w;

    // ---------------- access qualification ----------------
    assign loc_ok      = (owner_loc == acc_loc);
    assign sts_hit     = (reg_addr == ADDR_W'(OFS_STS));
    assign fifo_hit    = (reg_addr == ADDR_W'(OFS_FIFO));
    assign cmd_rdy_req = reg_wr && loc_ok && sts_hit && reg_wdata[BIT_CRDY];
    assign go_req      = reg_wr && loc_ok && sts_hit && reg_wdata[BIT_GO] && !cmd_rdy_req;
    assign wr_fifo     = reg_wr && loc_ok && fifo_hit;
    assign rd_fifo     = reg_rd && loc_ok && fifo_hit;

    // ---------------- reception bookkeeping ----------------
    assign need_more    = !len_known_q || ({{(32-CNT_W){1'b0}}, wr_cnt_q} < len_q);
    assign byte_take    = wr_fifo &&
                          ((state_q == ST_READY) ||
                           (state_q == ST_RX && need_more && wr_cnt_q < CNT_W'(DEPTH)));
    assign hit_len_last = byte_take && (wr_cnt_q == CNT_W'(LEN_LAST));
    assign len_bad      = hit_len_last &&
                          ((len_nx < 32'(HDR_BYTES)) || (len_nx > 32'(DEPTH)));
    assign shift_en     = byte_take && (wr_cnt_q >= CNT_W'(LEN_FIRST)) &&
                          (wr_cnt_q <= CNT_W'(LEN_LAST));
    assign exec_done    = (state_q == ST_EXEC) && (exec_cnt_q == EL_W'(EXEC_LAT - 1));
    assign unread_w     = len_q[CNT_W-1:0] - rd_cnt_q;
    assign pop          = rd_fifo && (state_q == ST_COMPL) && (unread_w != '0);
    assign clr_all      = cmd_rdy_req || len_bad;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (cmd_rdy_req) begin
            state_d = ST_READY;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_READY: if (byte_take) state_d = ST_RX;
                ST_RX: begin
                    if (len_bad)                     state_d = ST_READY;
                    else if (go_req && !need_more)   state_d = ST_EXEC;
                end
                ST_EXEC:  if (exec_done) state_d = ST_COMPL;
                ST_COMPL: state_d = ST_COMPL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            wr_cnt_q    <= '0;
            rd_cnt_q    <= '0;
            len_known_q <= 1'b0;
        end else begin
            if (byte_take)    wr_cnt_q    <= wr_cnt_q + 1'b1;
            if (pop)          rd_cnt_q    <= rd_cnt_q + 1'b1;
            if (hit_len_last) len_known_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_cnt_q <= '0;
        end else if (state_q == ST_RX && state_d == ST_EXEC) begin
            exec_cnt_q <= '0;
        end else if (state_q == ST_EXEC) begin
            exec_cnt_q <= exec_cnt_q + 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sts_valid  = (state_q != ST_EXEC);
        sts_crdy   = (state_q == ST_READY);
        sts_expect = (state_q == ST_RX) && need_more;
        sts_avail  = (state_q == ST_COMPL) && (unread_w != '0);
        sts_byte   = '0;
        sts_byte[BIT_VALID]  = sts_valid;
        sts_byte[BIT_CRDY]   = sts_crdy;
        sts_byte[BIT_AVAIL]  = sts_avail;
        sts_byte[BIT_EXPECT] = sts_expect;
        unique case (state_q)
            ST_READY, ST_RX: burst_w = 16'(DEPTH) - 16'(wr_cnt_q);
            ST_COMPL:        burst_w = 16'(unread_w);
            default:         burst_w = '0;
        endcase
    end

    // ---------------- sub-blocks ----------------
    xse_len_capture u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .shift_en (shift_en),
        .byte_in  (reg_wdata),
        .len_q    (len_q),
        .len_nx   (len_nx)
    );

    // stub executor: the command bytes stay in place and are replayed as the response
    xse_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (byte_take),
        .waddr (wr_cnt_q[AW-1:0]),
        .wdata (reg_wdata),
        .raddr (rd_cnt_q[AW-1:0]),
        .rdata (buf_rdata)
    );

    xse_readmux #(.ADDR_W(ADDR_W)) u_mux (
        .addr      (reg_addr),
        .loc_ok    (loc_ok),
        .sts_byte  (sts_byte),
        .burst     (burst_w),
        .fifo_ok   (sts_avail),
        .fifo_byte (buf_rdata),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/xse_checker.sv
module xse_checker #(
    parameter int LOC_W  = 3,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LOC_W-1:0]    owner_loc,
    input logic [LOC_W-1:0]    acc_loc,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [7:0]          reg_wdata,
    input xse_pkg::xse_state_e state_q,
    input logic [CNT_W-1:0]    wr_cnt_q,
    input logic                sts_avail,
    input logic                sts_valid,
    input logic [15:0]         burst_w
);

    import xse_pkg::*;

    logic own_acc;
    assign own_acc = (owner_loc == acc_loc);

    AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && own_acc && reg_addr == ADDR_W'(OFS_STS) && reg_wdata[BIT_CRDY])
        |=> (state_q == ST_READY)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_q <= CNT_W'(DEPTH)); // R4

    AST_EXEC_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |-> (burst_w == 16'd0)); // R6

    AST_GO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && $past(state_q) != ST_EXEC) |-> ($past(state_q) == ST_RX)); // R7

    AST_AVAIL_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_avail |-> (state_q == ST_COMPL && sts_valid)); // R8

    AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !own_acc && state_q != ST_EXEC) |=> $stable(state_q)); // R10

endmodule

bind xfer_status_engine xse_checker #(
    .LOC_W(LOC_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner_loc (owner_loc),
    .acc_loc   (acc_loc),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .state_q   (state_q),
    .wr_cnt_q  (wr_cnt_q),
    .sts_avail (sts_avail),
    .sts_valid (sts_valid),
    .burst_w   (burst_w)
);

// File: tb/sim_xfer_status_engine.sv
module sim_xfer_status_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam logic [2:0]  OWN   = 3'd0;
    localparam logic [2:0]  OTHER = 3'd2;
    localparam logic [11:0] A_STS = 12'h018;
    localparam logic [11:0] A_B0  = 12'h019;
    localparam logic [11:0] A_B1  = 12'h01A;
    localparam logic [11:0] A_FIFO = 12'h024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  acc_loc = OWN;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] exp_q[$];

    xfer_status_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner_loc (OWN),
        .acc_loc   (acc_loc),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] loc, logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        acc_loc = loc; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0; acc_loc = OWN;
    endtask

    task automatic rd(logic [2:0] loc, logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_loc = loc; reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0; acc_loc = OWN;
    endtask

    task automatic chk_sts(string req, int exp);
        logic [7:0] v;
        rd(OWN, A_STS, v);
        check(req, v, exp);
    endtask

    task automatic chk_burst(string req, int exp);
        logic [7:0] lo, hi;
        rd(OWN, A_B0, lo);
        rd(OWN, A_B1, hi);
        check(req, {hi, lo}, exp);
    endtask

    function automatic logic [7:0] cmd_byte(int len, int i);
        case (i)
            0: return 8'h80;
            1: return 8'hC1;
            2: return len[31:24];
            3: return len[23:16];
            4: return len[15:8];
            5: return len[7:0];
            default: return 8'(i) ^ 8'h5A;
        endcase
    endfunction

    // driver: writes bytes [from, to) of a command, queuing those that should be kept
    task automatic send(int len, int from, int to);
        for (int i = from; i < to; i++) begin
            wr(OWN, A_FIFO, cmd_byte(len, i));
            if (i < len) exp_q.push_back(cmd_byte(len, i));
        end
    endtask

    // monitor: pops one response byte and compares with the queue head
    task automatic pop_chk(string req);
        logic [7:0] v;
        logic [7:0] e;
        rd(OWN, A_FIFO, v);
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
        check(req, v, e);
    endtask

    task automatic go_and_wait();
        wr(OWN, A_STS, 8'h20);
        chk_sts("R8 exec cycle 1", 8'h00);
        chk_sts("R8 exec cycle 2", 8'h00);
        chk_sts("R8 completion", 8'h90);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk_sts("R1 status", 8'h80);
        chk_burst("R1 burst", 0);

        // R10 foreign locality
        wr(OTHER, A_STS, 8'h40);
        chk_sts("R10 foreign write ignored", 8'h80);
        rd(OTHER, A_STS, v);
        check("R10 foreign read", v, 8'hFF);

        // R2 enter ready
        wr(OWN, A_STS, 8'h40);
        chk_sts("R2 ready status", 8'hC0);
        chk_burst("R2 ready burst", DEPTH);

        // R11 fifo read outside completion
        rd(OWN, A_FIFO, v);
        check("R11 fifo read in ready", v, 8'h00);
        chk_sts("R11 state unchanged", 8'hC0);

        // R3 reception, R7 early go ignored
        exp_q.delete();
        send(12, 0, 11);
        chk_sts("R3 expect set", 8'h88);
        chk_burst("R6 free space", DEPTH - 11);
        wr(OWN, A_STS, 8'h20);
        chk_sts("R7 go ignored while expecting", 8'h88);
        wr(OTHER, A_FIFO, 8'hEE);
        chk_burst("R10 foreign fifo write dropped", DEPTH - 11);
        send(12, 11, 12);
        chk_sts("R3 expect clear", 8'h80);
        chk_burst("R6 free after last", DEPTH - 12);
        send(12, 12, 13);
        chk_burst("R4 extra byte dropped", DEPTH - 12);

        // R8 execution, R9 response
        go_and_wait();
        chk_burst("R6 unread count", 12);
        for (int i = 0; i < 5; i++) pop_chk("R9 response byte");
        chk_burst("R6 unread after 5", 7);
        for (int i = 0; i < 7; i++) pop_chk("R9 response byte");
        chk_sts("R9 avail clear after drain", 8'h80);
        rd(OWN, A_FIFO, v);
        check("R11 read after drain", v, 8'h00);

        // R2 abort from completion
        wr(OWN, A_STS, 8'h40);
        chk_sts("R2 abort from completion", 8'hC0);

        // R5 bad lengths
        exp_q.delete();
        send(8, 0, 6);
        chk_sts("R5 short length", 8'hC0);
        chk_burst("R5 short length burst", DEPTH);
        send(65, 0, 6);
        chk_sts("R5 long length", 8'hC0);
        chk_burst("R5 long length burst", DEPTH);
        exp_q.delete();

        // R2 abort mid reception
        send(20, 0, 3);
        wr(OWN, A_STS, 8'h40);
        chk_sts("R2 abort mid reception", 8'hC0);
        chk_burst("R2 abort burst", DEPTH);
        exp_q.delete();

        // full buffer command
        send(DEPTH, 0, DEPTH);
        chk_sts("R3 full command expect clear", 8'h80);
        chk_burst("R6 buffer full", 0);
        send(DEPTH, DEPTH, DEPTH + 1);
        chk_burst("R4 write into full buffer", 0);
        go_and_wait();
        chk_burst("R6 unread full", DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_chk("R9 full response byte");
        chk_sts("R9 full drain", 8'h80);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule